// File: doc/BRIEF.md
# Load Pipeline Entry Arbiter

This block sits in front of stage 0 of a load pipeline. Each cycle it picks at most one request from six sources, which are ranked in a fixed order. It hands the chosen request's address and tag to stage 0, and it marks the request as a prefetch and/or a first issue. The sources are:

- load-store-queue replays;
- a high-confidence hardware prefetcher;
- reservation-station first issues (integer loads or software prefetches);
- vector first issues;
- a speculative pointer-chasing fast path;
- a lower-confidence hardware prefetcher.

Every source has a valid/ready handshake. Only the winner sees ready, and only while stage 0 can accept. A sender whose request is not accepted keeps its payload stable until it is.

An accepted flow is registered into a one-entry stage-1 slot. There, the block combines the flow's kind with the TLB miss result for that cycle. From these it decides whether the flow may later be replayed, and whether it should feed the prefetch trainer.

Top module: `ld_entry_arb`

## Requirements
- R1: After reset, and until the first accepted request, `s1_valid_o` is low.
- R2: Source identifiers are 0 = queue replay, 1 = high-confidence hardware prefetch, 2 = reservation-station issue, 3 = vector issue, 4 = fast path, 5 = low-confidence hardware prefetch. Among the requesting sources, the lowest identifier wins and is reported on `s0_src_o`.
- R3: The fast path (bit 4) can win only when none of bits 0, 2 or 3 of `req_valid_i` is set.
- R4: `req_ready_o` has at most one bit set: the winner's bit, and only while `pipe_ready_i` is high. When `pipe_ready_i` is low, all ready bits are low.
- R5: `s0_valid_o` is high exactly when some `req_valid_i` bit is set. `s0_addr_o` and `s0_tag_o` equal the winner's slice of `req_addr_i` and `req_tag_i`.
- R6: `s0_first_issue_o` is high for sources 2 and 3. It is low for sources 0, 1, 4 and 5.
- R7: `s0_prefetch_o` is high for sources 1 and 5. It is also high for source 2 when `rs_swpf_i` is high. Otherwise it is low.
- R8: A request accepted on a clock edge shows up one cycle later on `s1_valid_o` and `s1_src_o`. In that cycle, `s1_replay_ok_o` follows these rules:
  - low for hardware prefetches (sources 1, 5), whatever the TLB result;
  - for a software prefetch, equal to `s1_tlb_miss_i`;
  - high for every other flow.
- R9: `s1_train_o` is high only for a stage-1 flow that is a first issue and not a prefetch.
- R10: A cycle with `pipe_ready_i` low moves nothing into stage 1: `s1_valid_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 6 | Per-source request valid, bit index = source id |
| req_addr_i | input | 6*ADDR_W | Per-source address |
| req_tag_i | input | 6*TAG_W | Per-source tag |
| rs_swpf_i | input | 1 | Source-2 request is a software prefetch |
| req_ready_o | output | 6 | Per-source accept |
| pipe_ready_i | input | 1 | Stage 0 can accept |
| s0_valid_o | output | 1 | A request is presented to stage 0 |
| s0_src_o | output | 3 | Winning source id |
| s0_addr_o | output | ADDR_W | Winner's address |
| s0_tag_o | output | TAG_W | Winner's tag |
| s0_first_issue_o | output | 1 | Winner is a first issue |
| s0_prefetch_o | output | 1 | Winner is a prefetch |
| s1_tlb_miss_i | input | 1 | TLB miss for the stage-1 flow |
| s1_valid_o | output | 1 | Stage-1 slot holds a flow |
| s1_src_o | output | 3 | Stage-1 flow source id |
| s1_replay_ok_o | output | 1 | Stage-1 flow may be replayed |
| s1_train_o | output | 1 | Stage-1 flow feeds the prefetch trainer |

## Verification
The bench goes after four kinds of error.

- **Priority order.** It drives every suffix of the priority list, plus sparse mixes. A shuffled order or an off-by-one mask would grant the wrong source and forward the wrong address.
- **Stall.** It stalls the pipeline while requests wait. A design that leaks ready during a stall would drop or duplicate a request, and a stage 1 that loads regardless would show a phantom flow.
- **Flow kinds.** It sends software and hardware prefetches with and without a TLB miss. A design that treats these alike would let a hardware prefetch be replayed, would replay software prefetches that hit, or would train the prefetcher on prefetches.
- **Fast path.** It checks that the fast path wins only when nothing outranks it.

// File: rtl/ld_arb_pkg.sv
package ld_arb_pkg;

    localparam int unsigned NUM_SRC  = 6;
    localparam int unsigned SRC_ID_W = 3;

    typedef enum logic [SRC_ID_W-1:0] {
        SRC_LSQ_REPLAY = 3'd0,
        SRC_HWPF_HI    = 3'd1,
        SRC_RS_ISSUE   = 3'd2,
        SRC_VEC_ISSUE  = 3'd3,
        SRC_FAST_PATH  = 3'd4,
        SRC_HWPF_LO    = 3'd5
    } ld_src_e;

    typedef struct packed {
        logic    valid;
        ld_src_e src;
        logic    first_issue;
        logic    prefetch;
        logic    hw_pf;
        logic    sw_pf;
    } stage1_t;

endpackage

// File: rtl/ld_arb_pick.sv
module ld_arb_pick #(
    parameter int unsigned N    = 6,
    parameter int unsigned ID_W = 3
) (
    input  logic [N-1:0]    req_i,
    output logic [N-1:0]    grant_o,
    output logic [ID_W-1:0] id_o,
    output logic            any_o
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_grant
            if (i == 0) begin : g_top
                assign grant_o[i] = req_i[i];
            end else begin : g_low
                assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
            end
        end
    endgenerate

    always_comb begin
        id_o = '0;
        for (int k = 0; k < N; k++) begin
            if (grant_o[k]) id_o = ID_W'(k);
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/ld_arb_attr.sv
module ld_arb_attr
    import ld_arb_pkg::*;
(
    input  ld_src_e src_i,
    input  logic    rs_swpf_i,
    output logic    first_issue_o,
    output logic    prefetch_o,
    output logic    hw_pf_o,
    output logic    sw_pf_o
);

    always_comb begin
        first_issue_o = 1'b0;
        hw_pf_o       = 1'b0;
        sw_pf_o       = 1'b0;
        unique case (src_i)
            SRC_HWPF_HI, SRC_HWPF_LO: hw_pf_o = 1'b1;
            SRC_RS_ISSUE: begin
                first_issue_o = 1'b1;
                sw_pf_o       = rs_swpf_i;
            end
            SRC_VEC_ISSUE: first_issue_o = 1'b1;
            default: ;
        endcase
        prefetch_o = hw_pf_o | sw_pf_o;
    end

endmodule

// File: rtl/ld_entry_arb.sv
module ld_entry_arb
    import ld_arb_pkg::*;
#(
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned TAG_W  = 8
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic [NUM_SRC-1:0]              req_valid_i,
    input  logic [NUM_SRC-1:0][ADDR_W-1:0]  req_addr_i,
    input  logic [NUM_SRC-1:0][TAG_W-1:0]   req_tag_i,
    input  logic                            rs_swpf_i,
    output logic [NUM_SRC-1:0]              req_ready_o,
    input  logic                            pipe_ready_i,
    output logic                            s0_valid_o,
    output logic [SRC_ID_W-1:0]             s0_src_o,
    output logic [ADDR_W-1:0]               s0_addr_o,
    output logic [TAG_W-1:0]                s0_tag_o,
    output logic                            s0_first_issue_o,
    output logic                            s0_prefetch_o,
    input  logic                            s1_tlb_miss_i,
    output logic                            s1_valid_o,
    output logic [SRC_ID_W-1:0]             s1_src_o,
    output logic                            s1_replay_ok_o,
    output logic                            s1_train_o
);

    localparam int unsigned FAST_IDX = int'(SRC_FAST_PATH);

    logic [NUM_SRC-1:0]  req_gated;
    logic [NUM_SRC-1:0]  grant;
    logic [SRC_ID_W-1:0] win_id;
    logic                any_req;
    logic                fast_blocked;
    logic                first_issue, prefetch, hw_pf, sw_pf;
    logic                fire;
    stage1_t             s1_d, s1_q;

    // The fast path is speculative: any replayed or newly issued load shuts it out.
    always_comb begin
        fast_blocked = req_valid_i[SRC_LSQ_REPLAY] | req_valid_i[SRC_RS_ISSUE]
                     | req_valid_i[SRC_VEC_ISSUE];
        req_gated = req_valid_i;
        req_gated[FAST_IDX] = req_valid_i[FAST_IDX] & ~fast_blocked;
    end

    ld_arb_pick #(.N(NUM_SRC), .ID_W(SRC_ID_W)) u_pick (
        .req_i   (req_gated),
        .grant_o (grant),
        .id_o    (win_id),
        .any_o   (any_req)
    );

    ld_arb_attr u_attr (
        .src_i         (ld_src_e'(win_id)),
        .rs_swpf_i     (rs_swpf_i),
        .first_issue_o (first_issue),
        .prefetch_o    (prefetch),
        .hw_pf_o       (hw_pf),
        .sw_pf_o       (sw_pf)
    );

    always_comb begin
        s0_addr_o = '0;
        s0_tag_o  = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (grant[k]) begin
                s0_addr_o = req_addr_i[k];
                s0_tag_o  = req_tag_i[k];
            end
        end
    end

    assign s0_valid_o       = any_req;
    assign s0_src_o         = win_id;
    assign s0_first_issue_o = first_issue;
    assign s0_prefetch_o    = prefetch;
    assign req_ready_o      = pipe_ready_i ? grant : '0;
    assign fire             = any_req & pipe_ready_i;

    always_comb begin
        s1_d       = s1_q;
        s1_d.valid = fire;
        if (fire) begin
            s1_d.src         = ld_src_e'(win_id);
            s1_d.first_issue = first_issue;
            s1_d.prefetch    = prefetch;
            s1_d.hw_pf       = hw_pf;
            s1_d.sw_pf       = sw_pf;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s1_q <= '0;
        else         s1_q <= s1_d;
    end

    assign s1_valid_o     = s1_q.valid;
    assign s1_src_o       = s1_q.src;
    assign s1_replay_ok_o = s1_q.valid & ~s1_q.hw_pf & (~s1_q.sw_pf | s1_tlb_miss_i);
    assign s1_train_o     = s1_q.valid & s1_q.first_issue & ~s1_q.prefetch;

endmodule

// File: rtl/ld_arb_checker.sv
module ld_arb_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [5:0] req_valid_i,
    input logic [5:0] req_ready_o,
    input logic       pipe_ready_i,
    input logic       s0_valid_o,
    input logic [2:0] s0_src_o,
    input logic       s0_first_issue_o,
    input logic       s1_valid_o,
    input logic [2:0] s1_src_o,
    input logic       s1_replay_ok_o
);

    assert_one_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(req_ready_o));

    assert_stall_no_ready_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pipe_ready_i |-> (req_ready_o == 6'b0));

    assert_replay_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i[0] && pipe_ready_i) |-> req_ready_o[0]);

    assert_fast_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o[4] |-> !(req_valid_i[0] || req_valid_i[2] || req_valid_i[3]));

    assert_replayed_not_first_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s0_valid_o && s0_src_o == 3'd0) |-> !s0_first_issue_o);

    assert_hwpf_no_replay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s1_valid_o && (s1_src_o == 3'd1 || s1_src_o == 3'd5)) |-> !s1_replay_ok_o);

    assert_advance_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s0_valid_o && pipe_ready_i) |=> (s1_valid_o && s1_src_o == $past(s0_src_o)));

    assert_stall_empty_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pipe_ready_i |=> !s1_valid_o);

endmodule

bind ld_entry_arb ld_arb_checker u_ld_arb_checker (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_valid_i      (req_valid_i),
    .req_ready_o      (req_ready_o),
    .pipe_ready_i     (pipe_ready_i),
    .s0_valid_o       (s0_valid_o),
    .s0_src_o         (s0_src_o),
    .s0_first_issue_o (s0_first_issue_o),
    .s1_valid_o       (s1_valid_o),
    .s1_src_o         (s1_src_o),
    .s1_replay_ok_o   (s1_replay_ok_o)
);

// File: tb/test_ld_entry_arb.sv
`timescale 1ns/1ps
module test_ld_entry_arb;

    localparam int ADDR_W = 40;
    localparam int TAG_W  = 8;

    logic                      clk_i = 1'b0;
    logic                      rst_ni = 1'b0;
    logic [5:0]                req_valid_i = '0;
    logic [5:0][ADDR_W-1:0]    req_addr_i;
    logic [5:0][TAG_W-1:0]     req_tag_i;
    logic                      rs_swpf_i = 1'b0;
    logic [5:0]                req_ready_o;
    logic                      pipe_ready_i = 1'b0;
    logic                      s0_valid_o;
    logic [2:0]                s0_src_o;
    logic [ADDR_W-1:0]         s0_addr_o;
    logic [TAG_W-1:0]          s0_tag_o;
    logic                      s0_first_issue_o, s0_prefetch_o;
    logic                      s1_tlb_miss_i = 1'b0;
    logic                      s1_valid_o;
    logic [2:0]                s1_src_o;
    logic                      s1_replay_ok_o, s1_train_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk_i = ~clk_i;

    ld_entry_arb #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_ld_entry_arb (.*);

    // {valid[5:0], swpf, pipe_ready, exp_valid, exp_src[2:0], exp_first, exp_pf}
    localparam logic [13:0] VEC [0:13] = '{
        {6'b111111, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0},
        {6'b111110, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1},
        {6'b111100, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1, 1'b0},
        {6'b111100, 1'b1, 1'b1, 1'b1, 3'd2, 1'b1, 1'b1},
        {6'b111000, 1'b0, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0},
        {6'b110000, 1'b0, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0},
        {6'b100000, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1},
        {6'b000000, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0},
        {6'b010100, 1'b0, 1'b1, 1'b1, 3'd2, 1'b1, 1'b0},
        {6'b011000, 1'b0, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0},
        {6'b010001, 1'b0, 1'b1, 1'b1, 3'd0, 1'b0, 1'b0},
        {6'b010000, 1'b0, 1'b1, 1'b1, 3'd4, 1'b0, 1'b0},
        {6'b110010, 1'b0, 1'b1, 1'b1, 3'd1, 1'b0, 1'b1},
        {6'b111111, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_one(input int src, input bit swpf, input bit tlb, input bit exp_ok, input bit exp_train);
        @(negedge clk_i);
        req_valid_i  = 6'b1 << src;
        rs_swpf_i    = swpf;
        pipe_ready_i = 1'b1;
        @(negedge clk_i);
        req_valid_i   = '0;
        s1_tlb_miss_i = tlb;
        #1;
        check("R8", "s1_valid", 64'(s1_valid_o), 64'd1);
        check("R8", "s1_src", 64'(s1_src_o), 64'(src));
        check("R8", "replay_ok", 64'(s1_replay_ok_o), 64'(exp_ok));
        check("R9", "train", 64'(s1_train_o), 64'(exp_train));
    endtask

    initial begin
        for (int i = 0; i < 6; i++) begin
            req_addr_i[i] = ADDR_W'(64'hA000 + 64'(i) * 64'h10);
            req_tag_i[i]  = TAG_W'(8'h30 + i);
        end
        #1;
        check("R1", "s1_valid in reset", 64'(s1_valid_o), 64'd0);
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        #1;
        check("R1", "s1_valid after reset", 64'(s1_valid_o), 64'd0);

        for (int v = 0; v < 14; v++) begin
            logic [13:0] e;
            logic [5:0]  exp_rdy;
            e = VEC[v];
            @(negedge clk_i);
            req_valid_i  = e[13:8];
            rs_swpf_i    = e[7];
            pipe_ready_i = e[6];
            #1;
            exp_rdy = (e[6] && e[5]) ? (6'b1 << e[4:2]) : 6'b0;
            check("R5", "s0_valid", 64'(s0_valid_o), 64'(e[5]));
            check(e[6] ? "R2" : "R4", "ready", 64'(req_ready_o), 64'(exp_rdy));
            if (e[5]) begin
                check((e[4:2] == 3'd4) ? "R3" : "R2", "src", 64'(s0_src_o), 64'(e[4:2]));
                check("R5", "addr", 64'(s0_addr_o), 64'(req_addr_i[e[4:2]]));
                check("R5", "tag", 64'(s0_tag_o), 64'(req_tag_i[e[4:2]]));
                check("R6", "first_issue", 64'(s0_first_issue_o), 64'(e[1]));
                check("R7", "prefetch", 64'(s0_prefetch_o), 64'(e[0]));
            end
        end
        // The last vector held pipe_ready low with requests waiting.
        @(negedge clk_i);
        req_valid_i = '0;
        #1;
        check("R10", "s1_valid after stall", 64'(s1_valid_o), 64'd0);

        send_one(0, 1'b0, 1'b0, 1'b1, 1'b0);
        send_one(2, 1'b0, 1'b0, 1'b1, 1'b1);
        send_one(2, 1'b1, 1'b0, 1'b0, 1'b0);
        send_one(2, 1'b1, 1'b1, 1'b1, 1'b0);
        send_one(1, 1'b0, 1'b1, 1'b0, 1'b0);
        send_one(5, 1'b0, 1'b1, 1'b0, 1'b0);
        send_one(3, 1'b0, 1'b0, 1'b1, 1'b1);
        send_one(4, 1'b0, 1'b1, 1'b1, 1'b0);

        @(negedge clk_i);
        pipe_ready_i = 1'b0;
        req_valid_i  = 6'b000100;
        @(negedge clk_i);
        #1;
        check("R10", "stalled flow absent", 64'(s1_valid_o), 64'd0);
        check("R4", "no ready in stall", 64'(req_ready_o), 64'd0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule